// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Pin Interrupts

This block gives a host a bank of general-purpose pins behind a word-addressed 32-bit register port. Software chooses each pin's direction, drives output levels with separate write-one-to-set and write-one-to-clear registers, and reads the synchronized input levels. Each pin can also raise an interrupt. Per pin, the interrupt is configured for level or edge sensitivity and for high/rising or low/falling polarity. A separate enable bit and mask bit gate it, and its state shows in a pending register. All unmasked, enabled pending bits are OR-ed into one registered interrupt line toward the host.

The hardware has no mode that fires on both edges. Software gets that behaviour by rewriting a pin's polarity bit to the inverse of its current level after each event. Polarity is therefore a plain register that can be rewritten at any time, and each bit affects only its own pin. A build parameter flips the meaning of the direction register, so that a 1 marks an input instead of an output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (pinOutEn all 0), pinOut is all 0, the enable, mask, type, polarity and pending registers read 0, and irqOut is 0.
- R2: Writing the set register (offset 0x0C) drives high every pin whose data bit is 1 from the next cycle on. Pins whose data bit is 0 keep their level. Reading 0x0C or 0x10 returns the output levels.
- R3: Writing the clear register (offset 0x10) drives low every pin whose data bit is 1 from the next cycle on. Pins whose data bit is 0 keep their level.
- R4: The direction register (offset 0x00) is read/write. With OE_INVERT=0, a 1 bit sets pinOutEn for that pin. With OE_INVERT=1, a 1 bit clears it, and reset leaves the register all ones.
- R5: The input register (offset 0x04) shows pinIn through a two-flop synchronizer. A change made just after a clock edge is readable after the second following edge.
- R6: With type bit 0 (edge), a synchronized rising edge sets the pin's pending bit (offset 0x20) when polarity bit (offset 0x1C) is 1, and a falling edge sets it when polarity bit is 0. The opposite edge is ignored.
- R7: An edge pending bit stays set until 1 is written to that bit of the pending register. Writing 0 has no effect.
- R8: With type bit (offset 0x18) 1 (level), the pending bit equals the synchronized level when polarity is 1, and its inverse when polarity is 0, while enabled. Writes to the pending register do not change it.
- R9: A pin whose enable bit (offset 0x14) is 0 captures no pending event. Setting enable later does not recover events that occurred while it was 0.
- R10: irqOut is 1 exactly one cycle after some pin has pending, enable and mask (offset 0x24) bits all 1. The mask bit does not stop pending capture.
- R11: Register bits at or above PIN_COUNT read 0, and unmapped offsets read 0.
- R12: Rewriting the polarity register changes the detected edge only for the bits whose value changed, so software can alternate one pin's polarity while the other pins keep detecting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 6 | Byte offset of the register accessed |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Output level per pin |
| pinOutEn | output | PIN_COUNT | Output driver enable per pin |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The hardest situation to reach is the software emulation of both-edge detection. One pin must flip between rising and falling detection through polarity rewrites, while a second pin with untouched polarity still catches its own edge in the same pending word. The stimulus reaches it by rewriting the whole polarity word with only one bit changed, and by driving pin levels so that each pin sees both an edge that should be ignored and an edge that should be caught. The registered irqOut is checked in the cycle right after a mask write and again one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_DIR   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_IN    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SET   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_ITYPE = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_IPOL  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_IPEND = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_IMASK = 6'h24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_IN,
    SEL_OUT,
    SEL_IEN,
    SEL_ITYPE,
    SEL_IPOL,
    SEL_IPEND,
    SEL_IMASK
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrSet;
    logic    wrClr;
    logic    wrIen;
    logic    wrType;
    logic    wrPol;
    logic    wrPendClr;
    logic    wrMask;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] syncPrev
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= stage[STAGES-1];
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);

  regSel_e sel;

  always_comb begin
    unique case (regAddr)
      OFF_DIR:   sel = SEL_DIR;
      OFF_IN:    sel = SEL_IN;
      OFF_SET:   sel = SEL_OUT;
      OFF_CLR:   sel = SEL_OUT;
      OFF_IEN:   sel = SEL_IEN;
      OFF_ITYPE: sel = SEL_ITYPE;
      OFF_IPOL:  sel = SEL_IPOL;
      OFF_IPEND: sel = SEL_IPEND;
      OFF_IMASK: sel = SEL_IMASK;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = sel;
    strobe.wrDir     = regWrEn && (regAddr == OFF_DIR);
    strobe.wrSet     = regWrEn && (regAddr == OFF_SET);
    strobe.wrClr     = regWrEn && (regAddr == OFF_CLR);
    strobe.wrIen     = regWrEn && (regAddr == OFF_IEN);
    strobe.wrType    = regWrEn && (regAddr == OFF_ITYPE);
    strobe.wrPol     = regWrEn && (regAddr == OFF_IPOL);
    strobe.wrPendClr = regWrEn && (regAddr == OFF_IPEND);
    strobe.wrMask    = regWrEn && (regAddr == OFF_IMASK);
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] wrBits,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);

  localparam logic [PIN_COUNT-1:0] DIR_RESET = OE_INVERT ? '1 : '0;

  logic [PIN_COUNT-1:0] dirReg, outReg, ienReg, typeReg, polReg, maskReg;
  logic [PIN_COUNT-1:0] pendEdge, pendView;
  logic [PIN_COUNT-1:0] syncNow, syncPrev;
  logic [PIN_COUNT-1:0] edgeHit, levelHit;
  logic [PIN_COUNT-1:0] clrBits;

  gpio_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (pinIn),
    .syncOut  (syncNow),
    .syncPrev (syncPrev)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= DIR_RESET;
      ienReg  <= '0;
      typeReg <= '0;
      polReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= wrBits;
      if (strobe.wrIen)  ienReg  <= wrBits;
      if (strobe.wrType) typeReg <= wrBits;
      if (strobe.wrPol)  polReg  <= wrBits;
      if (strobe.wrMask) maskReg <= wrBits;
    end
  end

  // output level: set and clear act only on the bits written as 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outReg <= '0;
    else if (strobe.wrSet) outReg <= outReg | wrBits;
    else if (strobe.wrClr) outReg <= outReg & ~wrBits;
  end

  if (OE_INVERT) begin : g_oe_low
    assign pinOutEn = ~dirReg;
  end else begin : g_oe_high
    assign pinOutEn = dirReg;
  end
  assign pinOut = outReg;

  // per-pin trigger detection
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic riseSeen, fallSeen;
    assign riseSeen    = syncNow[p] & ~syncPrev[p];
    assign fallSeen    = ~syncNow[p] & syncPrev[p];
    assign edgeHit[p]  = polReg[p] ? riseSeen : fallSeen;
    assign levelHit[p] = polReg[p] ? syncNow[p] : ~syncNow[p];
  end

  assign clrBits = strobe.wrPendClr ? wrBits : '0;

  // edge pending: a new detection wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendEdge <= '0;
    else       pendEdge <= ((pendEdge & ~clrBits) | (edgeHit & ienReg)) & ~typeReg;
  end

  assign pendView = pendEdge | (typeReg & levelHit & ienReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(pendView & ienReg & maskReg);
  end

  // read mux, zero-extended above PIN_COUNT
  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      SEL_DIR:   rdData[PIN_COUNT-1:0] = dirReg;
      SEL_IN:    rdData[PIN_COUNT-1:0] = syncNow;
      SEL_OUT:   rdData[PIN_COUNT-1:0] = outReg;
      SEL_IEN:   rdData[PIN_COUNT-1:0] = ienReg;
      SEL_ITYPE: rdData[PIN_COUNT-1:0] = typeReg;
      SEL_IPOL:  rdData[PIN_COUNT-1:0] = polReg;
      SEL_IPEND: rdData[PIN_COUNT-1:0] = pendView;
      SEL_IMASK: rdData[PIN_COUNT-1:0] = maskReg;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);

  ctrlStrobe_t strobe;

  gpio_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT), .OE_INVERT(OE_INVERT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrBits   (regWrData[PIN_COUNT-1:0]),
    .pinIn    (pinIn),
    .rdData   (regRdData),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit OE_INVERT = 1'b0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOutEn,
  input logic                 irqOut
);

  assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_SET) |=>
      ((pinOut & $past(regWrData[PIN_COUNT-1:0])) == $past(regWrData[PIN_COUNT-1:0])));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_CLR) |=>
      ((pinOut & $past(regWrData[PIN_COUNT-1:0])) == '0));

  assert_output_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == OFF_SET || regAddr == OFF_CLR)) |=> $stable(pinOut));

  assert_dir_sense_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_DIR) |=>
      (pinOutEn == (OE_INVERT ? ~$past(regWrData[PIN_COUNT-1:0])
                              : $past(regWrData[PIN_COUNT-1:0]))));

  assert_upper_bits_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:PIN_COUNT] == '0);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_IEN && regWrData[PIN_COUNT-1:0] == '0) |=> ##1 !irqOut);

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_IMASK && regWrData[PIN_COUNT-1:0] == '0) |=> ##1 !irqOut);

endmodule

bind gpio_irq_bank gpio_irq_chk #(.PIN_COUNT(PIN_COUNT), .OE_INVERT(OE_INVERT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .pinOut    (pinOut),
  .pinOutEn  (pinOutEn),
  .irqOut    (irqOut)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  import gpio_irq_pkg::*;

  localparam int PINS = 16;

  typedef struct {
    int          kind;   // 0 read data, 1 irqOut, 2 pinOut, 3 pinOutEn
    logic [31:0] expVal;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [PINS-1:0]   pinIn = '0;
  logic [PINS-1:0]   pinOut, pinOutEn;
  logic              irqOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  item_t expQ[$];

  always #2 clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(PINS), .OE_INVERT(1'b0)) i_gpio_irq_bank (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOutEn  (pinOutEn),
    .irqOut    (irqOut)
  );

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = regRdData;
        1: act = {31'd0, irqOut};
        2: act = {16'd0, pinOut};
        default: act = {16'd0, pinOutEn};
      endcase
      testCnt++;
      if (act !== it.expVal) begin
        failCnt++;
        $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h", it.req, it.kind, act, it.expVal);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.kind = 0; it.expVal = e; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic checkPort(input int k, input logic [31:0] e, input string r, input bit waitEdge);
    item_t it;
    if (waitEdge) begin
      @(posedge clk); #1;
    end
    it.kind = k; it.expVal = e; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic setPins(input logic [PINS-1:0] v);
    @(posedge clk); #1;
    pinIn = v;
  endtask

  initial begin
    tick(3); #1;
    rstN = 1'b1;

    // R1 reset state
    doRead(OFF_DIR, 32'h0, "R1");
    checkPort(3, 32'h0, "R1", 1'b0);
    checkPort(2, 32'h0, "R1", 1'b0);
    checkPort(1, 32'h0, "R1", 1'b0);
    doRead(OFF_IEN, 32'h0, "R1");
    doRead(OFF_IPEND, 32'h0, "R1");

    // R4 direction register
    doWrite(OFF_DIR, 32'h0000_00FF);
    checkPort(3, 32'h0000_00FF, "R4", 1'b1);
    doRead(OFF_DIR, 32'h0000_00FF, "R4");

    // R2 / R3 set and clear
    doWrite(OFF_SET, 32'h0000_0005);
    checkPort(2, 32'h0000_0005, "R2", 1'b1);
    doWrite(OFF_SET, 32'h0000_0010);
    checkPort(2, 32'h0000_0015, "R2", 1'b1);
    doWrite(OFF_CLR, 32'h0000_0004);
    checkPort(2, 32'h0000_0011, "R3", 1'b1);
    doRead(OFF_CLR, 32'h0000_0011, "R3");

    // R11 upper bits and unmapped offset
    doWrite(OFF_DIR, 32'hFFFF_FFFF);
    doRead(OFF_DIR, 32'h0000_FFFF, "R11");
    doRead(6'h08, 32'h0, "R11");
    doWrite(OFF_DIR, 32'h0000_00FF);

    // R5 two-flop synchronizer latency
    setPins(16'h00A0);
    doRead(OFF_IN, 32'h0, "R5");
    doRead(OFF_IN, 32'h0000_00A0, "R5");

    // R6 rising edge on pin 8
    doWrite(OFF_IPOL, 32'h0000_0100);
    doWrite(OFF_IEN, 32'h0000_0100);
    doWrite(OFF_IMASK, 32'h0000_0100);
    doRead(OFF_IPEND, 32'h0, "R6");
    setPins(16'h01A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0000_0100, "R6");
    checkPort(1, 32'h1, "R10", 1'b0);

    // R7 write-one-to-clear
    doWrite(OFF_IPEND, 32'h0);
    doRead(OFF_IPEND, 32'h0000_0100, "R7");
    doWrite(OFF_IPEND, 32'h0000_0100);
    doRead(OFF_IPEND, 32'h0, "R7");
    checkPort(1, 32'h0, "R7", 1'b0);

    // R6 falling edge ignored under rising polarity
    setPins(16'h00A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0, "R6");

    // R12 per-bit polarity rewrite: pin 8 falling, pin 9 rising
    doWrite(OFF_IPOL, 32'h0000_0200);
    setPins(16'h01A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0, "R12");
    setPins(16'h00A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0000_0100, "R6");
    doWrite(OFF_IEN, 32'h0000_0300);
    setPins(16'h02A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0000_0300, "R12");
    doWrite(OFF_IPEND, 32'h0000_0300);
    doRead(OFF_IPEND, 32'h0, "R7");

    // R9 disabled pins capture nothing
    doWrite(OFF_IEN, 32'h0);
    setPins(16'h00A0);
    tick(4);
    setPins(16'h02A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0, "R9");
    checkPort(1, 32'h0, "R9", 1'b0);
    doWrite(OFF_IEN, 32'h0000_0300);
    tick(2);
    doRead(OFF_IPEND, 32'h0, "R9");

    // R10 mask gates only the combined line, registered output
    setPins(16'h00A0);
    tick(4);
    setPins(16'h02A0);
    tick(4);
    doRead(OFF_IPEND, 32'h0000_0200, "R10");
    checkPort(1, 32'h0, "R10", 1'b0);
    doWrite(OFF_IMASK, 32'h0000_0300);
    checkPort(1, 32'h0, "R10", 1'b0);
    checkPort(1, 32'h1, "R10", 1'b1);
    doWrite(OFF_IPEND, 32'h0000_0200);
    tick(2);
    checkPort(1, 32'h0, "R7", 1'b1);

    // R8 level sensitivity on pin 10
    doWrite(OFF_ITYPE, 32'h0000_0400);
    doWrite(OFF_IPOL, 32'h0000_0600);
    doWrite(OFF_IEN, 32'h0000_0700);
    doWrite(OFF_IMASK, 32'h0000_0700);
    doRead(OFF_IPEND, 32'h0, "R8");
    setPins(16'h06A0);
    tick(3);
    doRead(OFF_IPEND, 32'h0000_0400, "R8");
    checkPort(1, 32'h1, "R8", 1'b1);
    doWrite(OFF_IPEND, 32'h0000_0400);
    doRead(OFF_IPEND, 32'h0000_0400, "R8");
    setPins(16'h02A0);
    tick(3);
    doRead(OFF_IPEND, 32'h0, "R8");
    doWrite(OFF_IPOL, 32'h0000_0200);
    doRead(OFF_IPEND, 32'h0000_0400, "R8");
    doRead(OFF_IN, 32'h0000_02A0, "R5");

    tick(2);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule